// File: doc/BRIEF.md
# Field and Line Sequencer for a Composite Video Encoder

This block turns a stream of line-start strobes into a line number and a field identity for a composite video encoder. It also raises a one-cycle pulse at the start of every field and another at the start of every frame. A two-bit field mode picks interlaced timing or one of two progressive line totals. A standard select picks the 50 Hz or the 60 Hz line budget.

In interlaced timing, each field holds a whole number of lines plus one half line. To place the half line, the block counts pixel clocks from the strobe of the last line of the odd field. It ends that field halfway through the line and opens the even field there. The mode and the standard are sampled only when a frame opens, so a change never shortens a field that is already running. Downstream timing logic uses the line number and the pulses to place sync, blanking and inserted data lines.

Top module: `field_line_timer`

## Requirements
- R1: While reset is held, and after it until the first line-start strobe, the line number is 0, the odd-field flag is 1, and both start pulses are low. The first line-start strobe opens a frame.
- R2: Line numbers count from 1 on the first line of every field. Each later line-start strobe inside a field adds one in the following cycle. With no strobe and no field start, the line number holds.
- R3: Mode code 00 is interlaced with base count N. The odd field runs lines 1 to N+1, and it ends HALF_CLKS clocks after the strobe of line N+1. The even field starts at that instant with the flag at 0, and its line 1 is the second half of that line. Its lines 2 to N+1 are full lines. The strobe that follows even line N+1 opens the next frame.
- R4: Mode code 01 is progressive with N lines per field. Every field is a whole frame, and the odd-field flag stays at 1.
- R5: Mode code 10 is progressive with N+1 lines per field. Every field is a whole frame, and the odd-field flag stays at 1.
- R6: Mode code 11 produces exactly the timing of code 10.
- R7: Standard select 0 makes N equal LINES_50 (default 312). Standard select 1 makes N equal LINES_60 (default 262).
- R8: Mode and standard inputs are sampled only on the strobe that opens a frame. A change during a frame leaves the rest of that frame unchanged.
- R9: The field-start pulse is high for one cycle as each field opens. The frame-start pulse is high only together with a field-start pulse that opens an odd field at line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle strobe at the first pixel of every line |
| modeSel | input | 2 | Field mode code (00 interlaced, 01 short progressive, 10 and 11 long progressive) |
| stdSel | input | 1 | 0 selects 50 Hz line totals, 1 selects 60 Hz |
| lineNum | output | LW | Line number within the current field, 0 before the first line |
| fieldOdd | output | 1 | 1 during the odd field, 0 during the even field |
| fieldStart | output | 1 | One-cycle pulse when a field opens |
| frameStart | output | 1 | One-cycle pulse when a frame opens |

## Verification
The bench builds the block with HALF_CLKS = 2, LINES_50 = 5 and LINES_60 = 3, and it spaces line strobes four clocks apart. This makes the fields 12 to 24 clocks long. Every mode code under both standards then completes several frames in a short run. The half-line split shows up as two fields of 22 clocks (or 14 clocks at 60 Hz) between 20 and 24. The last-line compares, the half-line hand-over and the frame-boundary sampling of a changed mode are the same logic at full size, so they are exercised directly rather than scaled.

// File: rtl/field_line_timer_pkg.sv
package field_line_timer_pkg;

  typedef enum logic [1:0] {
    FM_INTERLACE = 2'b00,
    FM_SHORT     = 2'b01,
    FM_LONG      = 2'b10,
    FM_LONG_ALT  = 2'b11
  } fieldMode_t;

  typedef struct packed {
    logic newFrame;
    logic halfSwitch;
    logic nextLine;
  } lineStrobe_t;

endpackage

// File: rtl/field_line_ctrl.sv
module field_line_ctrl
  import field_line_timer_pkg::*;
#(
  parameter int HALF_CLKS = 864,
  parameter int LINES_50  = 312,
  parameter int LINES_60  = 262,
  parameter int LW        = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic [LW-1:0] lineNum,
  input  logic        fieldOdd,
  input  fieldMode_t  curMode,
  input  logic        curStd,
  output lineStrobe_t strobe
);

  localparam int PW = $clog2(HALF_CLKS + 2);
  localparam logic [PW-1:0] PIX_IDLE = PW'(HALF_CLKS + 1);
  localparam logic [PW-1:0] PIX_MID  = PW'(HALF_CLKS);
  localparam logic [LW-1:0] BASE50   = LW'(LINES_50);
  localparam logic [LW-1:0] BASE60   = LW'(LINES_60);

  logic [PW-1:0] pixCnt;
  logic [LW-1:0] baseLines;
  logic [LW-1:0] lastLine;
  logic          interlaced;
  logic          midLine;
  logic          endOfFrame;

  // Clocks since the last line strobe, parked past mid-line when idle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt <= PIX_IDLE;
    end else if (lineStart) begin
      pixCnt <= PW'(1);
    end else if (pixCnt != PIX_IDLE) begin
      pixCnt <= pixCnt + PW'(1);
    end
  end

  always_comb begin
    baseLines  = curStd ? BASE60 : BASE50;
    lastLine   = (curMode == FM_SHORT) ? baseLines : baseLines + LW'(1);
    interlaced = (curMode == FM_INTERLACE);
    midLine    = (pixCnt == PIX_MID);
    if (lineNum == '0) begin
      endOfFrame = 1'b1;
    end else if (interlaced) begin
      endOfFrame = !fieldOdd && (lineNum == lastLine);
    end else begin
      endOfFrame = (lineNum >= lastLine);
    end
    strobe.newFrame   = lineStart && endOfFrame;
    strobe.nextLine   = lineStart && !endOfFrame;
    strobe.halfSwitch = !lineStart && midLine && interlaced && fieldOdd
                        && (lineNum == lastLine);
  end

endmodule

// File: rtl/field_line_dpath.sv
module field_line_dpath
  import field_line_timer_pkg::*;
#(
  parameter int LW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  lineStrobe_t   strobe,
  input  logic [1:0]    modeIn,
  input  logic          stdIn,
  output logic [LW-1:0] lineNum,
  output logic          fieldOdd,
  output fieldMode_t    curMode,
  output logic          curStd,
  output logic          fieldStart,
  output logic          frameStart
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineNum    <= '0;
      fieldOdd   <= 1'b1;
      curMode    <= FM_INTERLACE;
      curStd     <= 1'b0;
      fieldStart <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      fieldStart <= strobe.newFrame || strobe.halfSwitch;
      frameStart <= strobe.newFrame;
      if (strobe.newFrame) begin
        lineNum  <= LW'(1);
        fieldOdd <= 1'b1;
        curMode  <= fieldMode_t'(modeIn);
        curStd   <= stdIn;
      end else if (strobe.halfSwitch) begin
        lineNum  <= LW'(1);
        fieldOdd <= 1'b0;
      end else if (strobe.nextLine) begin
        lineNum  <= lineNum + LW'(1);
      end
    end
  end

endmodule

// File: rtl/field_line_timer.sv
module field_line_timer
  import field_line_timer_pkg::*;
#(
  parameter int HALF_CLKS = 864,
  parameter int LINES_50  = 312,
  parameter int LINES_60  = 262,
  localparam int MAXL     = (LINES_50 > LINES_60) ? LINES_50 : LINES_60,
  localparam int LW       = $clog2(MAXL + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lineStart,
  input  logic [1:0]    modeSel,
  input  logic          stdSel,
  output logic [LW-1:0] lineNum,
  output logic          fieldOdd,
  output logic          fieldStart,
  output logic          frameStart
);

  lineStrobe_t strobe;
  fieldMode_t  curMode;
  logic        curStd;

  field_line_ctrl #(
    .HALF_CLKS(HALF_CLKS),
    .LINES_50 (LINES_50),
    .LINES_60 (LINES_60),
    .LW       (LW)
  ) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lineStart(lineStart),
    .lineNum  (lineNum),
    .fieldOdd (fieldOdd),
    .curMode  (curMode),
    .curStd   (curStd),
    .strobe   (strobe)
  );

  field_line_dpath #(
    .LW(LW)
  ) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeIn    (modeSel),
    .stdIn     (stdSel),
    .lineNum   (lineNum),
    .fieldOdd  (fieldOdd),
    .curMode   (curMode),
    .curStd    (curStd),
    .fieldStart(fieldStart),
    .frameStart(frameStart)
  );

endmodule

// File: rtl/field_line_timer_chk.sv
module field_line_timer_chk #(
  parameter int LW       = 9,
  parameter int LINES_50 = 312,
  parameter int LINES_60 = 262
) (
  input logic          clk,
  input logic          rstN,
  input logic          lineStart,
  input logic [LW-1:0] lineNum,
  input logic          fieldOdd,
  input logic          fieldStart,
  input logic          frameStart
);

  localparam int MAXL = (LINES_50 > LINES_60) ? LINES_50 : LINES_60;

  // R9
  frame_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (fieldStart && fieldOdd && lineNum == LW'(1)));

  // R9
  field_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> !fieldStart);

  // R2
  field_first_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |-> (lineNum == LW'(1)));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(lineStart) && !fieldStart) |-> $stable(lineNum));

  // R3
  half_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fieldOdd) |-> (fieldStart && !frameStart));

  // R4
  odd_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fieldOdd) |-> frameStart);

  // R5
  line_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineNum <= LW'(MAXL + 1));

endmodule

bind field_line_timer field_line_timer_chk #(
  .LW      (LW),
  .LINES_50(LINES_50),
  .LINES_60(LINES_60)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .lineStart (lineStart),
  .lineNum   (lineNum),
  .fieldOdd  (fieldOdd),
  .fieldStart(fieldStart),
  .frameStart(frameStart)
);

// File: tb/field_line_timer_test.sv
module field_line_timer_test;

  localparam int HALF   = 2;
  localparam int L50    = 5;
  localparam int L60    = 3;
  localparam int PERIOD = 2 * HALF;
  localparam int LW     = $clog2(L50 + 2);

  // mode, std, len of odd-opened field, len of next field, max line, odd flag of next field
  localparam int VEC [8][6] = '{
    '{0, 0, 22, 22, 6, 0},
    '{1, 0, 20, 20, 5, 1},
    '{2, 0, 24, 24, 6, 1},
    '{3, 0, 24, 24, 6, 1},
    '{0, 1, 14, 14, 4, 0},
    '{1, 1, 12, 12, 3, 1},
    '{2, 1, 16, 16, 4, 1},
    '{3, 1, 16, 16, 4, 1}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lineStart = 1'b0;
  logic [1:0]    modeSel = 2'b01;
  logic          stdSel = 1'b0;
  logic [LW-1:0] lineNum;
  logic          fieldOdd;
  logic          fieldStart;
  logic          frameStart;

  int  total = 0;
  int  fails = 0;
  bit  run = 1'b0;
  bit  finished = 1'b0;

  int fieldCnt = 0, frameCnt = 0;
  int curCnt = 0, curMax = 0, len1 = 0, len2 = 0, max1 = 0, max2 = 0;
  bit curOdd = 1'b0, odd1 = 1'b0, odd2 = 1'b0;

  always #10 clk = ~clk;

  field_line_timer #(
    .HALF_CLKS(HALF),
    .LINES_50 (L50),
    .LINES_60 (L60)
  ) uut (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .modeSel   (modeSel),
    .stdSel    (stdSel),
    .lineNum   (lineNum),
    .fieldOdd  (fieldOdd),
    .fieldStart(fieldStart),
    .frameStart(frameStart)
  );

  // Line strobe source: one pulse every PERIOD clocks while run is set
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      lineStart = run && (phase == 0);
      phase = run ? (phase + 1) % PERIOD : 0;
    end
  end

  // Field statistics gathered away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (fieldStart) begin
        len2 = len1;  len1 = curCnt;
        max2 = max1;  max1 = curMax;
        odd2 = odd1;  odd1 = curOdd;
        curCnt = 1;
        curMax = int'(lineNum);
        curOdd = fieldOdd;
        if (frameStart) frameCnt = frameCnt + 1;
        fieldCnt = fieldCnt + 1;
      end else begin
        curCnt = curCnt + 1;
        if (int'(lineNum) > curMax) curMax = int'(lineNum);
        curOdd = curOdd | fieldOdd;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total = total + 1;
      fails = fails + 1;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(lineNum == 0, "R1", "line in reset", int'(lineNum), 0);
    check(fieldOdd == 1'b1, "R1", "odd flag in reset", int'(fieldOdd), 1);
    check(!fieldStart && !frameStart, "R1", "pulses in reset",
          int'({fieldStart, frameStart}), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(lineNum == 0 && !fieldStart, "R1", "idle before first strobe",
          int'(lineNum), 0);
    run = 1'b1;
    wait (frameCnt == 1);
    check(lineNum == 1 && fieldOdd, "R1", "first strobe opens frame",
          int'(lineNum), 1);

    // R2: increment one clock after the strobe, hold otherwise
    repeat (PERIOD - 1) @(negedge clk);
    check(lineNum == 1, "R2", "hold between strobes", int'(lineNum), 1);
    @(negedge clk);
    check(lineNum == 2, "R2", "increment after strobe", int'(lineNum), 2);

    // Table walk over every mode code and both standards
    for (int v = 0; v < 8; v++) begin
      string req;
      int f0, fs, fr, expFrames;
      @(negedge clk);
      modeSel = VEC[v][0][1:0];
      stdSel  = VEC[v][1][0];
      case (VEC[v][0])
        0: req = "R3";
        1: req = "R4";
        2: req = "R5";
        default: req = "R6";
      endcase
      f0 = frameCnt;
      wait (frameCnt > f0);
      fs = fieldCnt;
      fr = frameCnt;
      check(lineNum == 1 && fieldOdd, "R2", "line 1 at frame open",
            int'(lineNum), 1);
      wait (fieldCnt == fs + 2);
      check(len2 == VEC[v][2], req, "first field length", len2, VEC[v][2]);
      check(len1 == VEC[v][3], req, "second field length", len1, VEC[v][3]);
      check(odd2 == 1'b1, req, "first field odd", int'(odd2), 1);
      check(odd1 == VEC[v][5][0], req, "second field odd flag",
            int'(odd1), VEC[v][5]);
      // R7: line total follows the standard select
      check(max2 == VEC[v][4] && max1 == VEC[v][4], "R7", "last line number",
            max2, VEC[v][4]);
      expFrames = (VEC[v][0] == 0) ? 1 : 2;
      check(frameCnt - fr == expFrames, "R9", "frame pulses per two fields",
            frameCnt - fr, expFrames);
    end

    // R8: mode change mid-frame waits for the next frame
    @(negedge clk);
    modeSel = 2'b01;
    stdSel  = 1'b0;
    begin
      int f0, fs;
      f0 = frameCnt;
      wait (frameCnt > f0);
      f0 = frameCnt;
      wait (frameCnt > f0);
      fs = fieldCnt;
      repeat (3) @(negedge clk);
      modeSel = 2'b10;
      stdSel  = 1'b1;
      wait (fieldCnt == fs + 1);
      check(len1 == 20, "R8", "running frame keeps old length", len1, 20);
      wait (fieldCnt == fs + 2);
      check(len1 == 16, "R8", "next frame uses new mode", len1, 16);
    end

    // R9: a field pulse in interlaced mode at the half line without frame pulse
    @(negedge clk);
    modeSel = 2'b00;
    stdSel  = 1'b0;
    begin
      int f0;
      f0 = frameCnt;
      wait (frameCnt > f0);
      wait (fieldStart && !fieldOdd);
      check(!frameStart, "R9", "no frame pulse at half line",
            int'(frameStart), 0);
      check(lineNum == 1, "R3", "even field starts at line 1",
            int'(lineNum), 1);
    end

    finished = 1'b1;
    summary();
  end

endmodule